// File: doc/BRIEF.md
# Conditional ALU Execute Stage

This block is the data-processing step of a 32-bit pipeline. Each clock it can accept one instruction made of a condition selector, an operation code, a flag-write request, a first operand, a second operand that has already passed through an external shifter, and that shifter's carry-out. It tests the selector against a four-bit status register that holds negative, zero, carry and overflow. It executes the instruction only when the test succeeds.

An executed instruction leaves its result in a registered output together with a one-cycle destination write strobe. When the flag-write request is set, it also loads new status bits. The four test-only operations compute a value, but they only ever change the status bits. Subtractions report carry as the inverse of borrow. Both reverse forms take the first operand away from the second. There is no handshake: the stage accepts whatever is presented on a cycle when `in_valid` is high.

The status register is compared before the current instruction updates it. As a result, an instruction placed directly behind a flag-setting one sees that instruction's flags.

Top module: `cond_alu_exec`

## Requirements
- R1: While `rst` is high at a clock edge, the flags (`flags_out`, ordered {N,Z,C,V} from bit 3 down), `res_out`, `res_we` and `executed` all become zero.
- R2: The condition selector is tested against the current flags: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never.
- R3: `executed` is high in the cycle after an edge where `in_valid` was high and the condition passed, and low otherwise. `res_we` is never high without `executed`.
- R4: Operation codes 0 AND, 1 XOR, 2 A-B, 3 B-A, 4 A+B, 5 A+B+C, 6 A-B+C-1, 7 B-A+C-1, 12 OR, 13 B, 14 A AND NOT B and 15 NOT B load their result into `res_out` with `res_we` high one cycle after an executed instruction. `res_out` changes at no other time.
- R5: Codes 8 (AND), 9 (XOR), 10 (A-B) and 11 (A+B) never raise `res_we`.
- R6: For codes 0, 1, 8, 9, 12, 13, 14 and 15, the new flags are N = result bit 31, Z = result zero, C = `shift_cout`, and V unchanged.
- R7: For the additions (4, 5, 11), C is the carry out of bit 31 and V is signed overflow. N and Z follow the result.
- R8: For the subtractions (2, 3, 6, 7, 10), C is high exactly when no borrow occurs and V is signed overflow of the operand order used. Codes 3 and 7 subtract A from B.
- R9: The flags change only at an edge where `in_valid`, `set_flags` and a passing condition coincide.
- R10: An instruction is tested against the flags left by the instruction immediately before it.
- R11: A cycle with `in_valid` low leaves the flags and `res_out` unchanged and gives `executed` and `res_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| cond_code | input | 4 | Condition selector |
| alu_op | input | 4 | Operation code |
| set_flags | input | 1 | Request to load the status flags |
| op_rn | input | W | First operand (A) |
| op_shift | input | W | Shifted second operand (B) |
| shift_cout | input | 1 | Carry-out of the external shifter |
| res_out | output | W | Last written result |
| res_we | output | 1 | Destination write strobe |
| executed | output | 1 | Previous instruction passed its condition |
| flags_out | output | 4 | Status flags {N,Z,C,V} |

## Verification
The hardest part to reach is every condition selector against every flag state. The flags can only be loaded through the ALU itself, and a result never has both N and Z set.

Before each test instruction, the bench issues an always-executed flag-setting add. Its operands (0x7FFFFFFF+1 or 0+0) fix V. A flag-setting move follows, and its operand and shifter carry fix N, Z and C while V is kept. This reaches all twelve flag combinations that can occur. Each combination is followed by every operation under every selector, with random operands and random flag requests.

Directed boundary pairs then exercise signed overflow, borrow, and carry-in on both reverse subtractions.

// File: rtl/cae_pkg.sv
package cae_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TAND = 4'd8, OP_TXOR = 4'd9, OP_CSUB = 4'd10, OP_CADD = 4'd11,
    OP_OR  = 4'd12, OP_MOV = 4'd13, OP_ANDN = 4'd14, OP_NOT = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int FLAG_W = 4;

  // true when the operation goes through the adder
  function automatic logic op_is_arith(input logic [3:0] op);
    return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
  endfunction

  // true for the flag-only operations
  function automatic logic op_is_test(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

endpackage

// File: rtl/cae_cond_eval.sv
module cae_cond_eval
  import cae_pkg::*;
(
  input  nzcv_t      flags,
  input  logic [3:0] cond,
  output logic       pass
);

  logic base;

  // even selector picks the base test, odd selector negates it
  always_comb begin
    unique case (cond[3:1])
      3'd0: base = flags.z;
      3'd1: base = flags.c;
      3'd2: base = flags.n;
      3'd3: base = flags.v;
      3'd4: base = flags.c & ~flags.z;
      3'd5: base = (flags.n == flags.v);
      3'd6: base = ~flags.z & (flags.n == flags.v);
      default: base = 1'b1;
    endcase
    pass = base ^ cond[0];
  end

endmodule

// File: rtl/cae_adder_sel.sv
module cae_adder_sel #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         cin
);

  // subtraction is x + ~y + 1; with carry it is x + ~y + C
  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    unique case (op)
      4'd2, 4'd10: begin x = a; y = ~b; cin = 1'b1; end
      4'd3:        begin x = b; y = ~a; cin = 1'b1; end
      4'd4, 4'd11: begin x = a; y = b;  cin = 1'b0; end
      4'd5:        begin x = a; y = b;  cin = c_in; end
      4'd6:        begin x = a; y = ~b; cin = c_in; end
      4'd7:        begin x = b; y = ~a; cin = c_in; end
      default:     begin x = a; y = b;  cin = 1'b0; end
    endcase
  end

endmodule

// File: rtl/cae_alu_core.sv
module cae_alu_core
  import cae_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         shc,
  input  nzcv_t        old_flags,
  output logic [W-1:0] result,
  output nzcv_t        new_flags
);

  localparam int MSB = W - 1;

  logic [W-1:0] add_x, add_y;
  logic         add_cin;
  logic [W:0]   add_sum;
  logic [W-1:0] logic_res;
  logic         arith;

  cae_adder_sel #(.W(W)) u_sel (
    .op   (op),
    .a    (a),
    .b    (b),
    .c_in (old_flags.c),
    .x    (add_x),
    .y    (add_y),
    .cin  (add_cin)
  );

  assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
  assign arith   = op_is_arith(op);

  always_comb begin
    unique case (op)
      4'd0, 4'd8:  logic_res = a & b;
      4'd1, 4'd9:  logic_res = a ^ b;
      4'd12:       logic_res = a | b;
      4'd13:       logic_res = b;
      4'd14:       logic_res = a & ~b;
      4'd15:       logic_res = ~b;
      default:     logic_res = a & b;
    endcase
  end

  always_comb begin
    result      = arith ? add_sum[W-1:0] : logic_res;
    new_flags.n = result[MSB];
    new_flags.z = (result == '0);
    if (arith) begin
      new_flags.c = add_sum[W];
      new_flags.v = (add_x[MSB] == add_y[MSB]) && (add_sum[MSB] != add_x[MSB]);
    end else begin
      new_flags.c = shc;
      new_flags.v = old_flags.v;
    end
  end

endmodule

// File: rtl/cond_alu_exec.sv
module cond_alu_exec
  import cae_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   cond_code,
  input  logic [3:0]   alu_op,
  input  logic         set_flags,
  input  logic [W-1:0] op_rn,
  input  logic [W-1:0] op_shift,
  input  logic         shift_cout,
  output logic [W-1:0] res_out,
  output logic         res_we,
  output logic         executed,
  output logic [3:0]   flags_out
);

  nzcv_t        flags_q;
  nzcv_t        flags_d;
  logic [W-1:0] alu_res;
  logic         cond_ok;
  logic         go;

  cae_cond_eval u_cond (
    .flags (flags_q),
    .cond  (cond_code),
    .pass  (cond_ok)
  );

  cae_alu_core #(.W(W)) u_alu (
    .op        (alu_op),
    .a         (op_rn),
    .b         (op_shift),
    .shc       (shift_cout),
    .old_flags (flags_q),
    .result    (alu_res),
    .new_flags (flags_d)
  );

  assign go = in_valid & cond_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      res_out  <= '0;
      res_we   <= 1'b0;
      executed <= 1'b0;
    end else begin
      executed <= go;
      res_we   <= go & ~op_is_test(alu_op);
      if (go & ~op_is_test(alu_op)) res_out <= alu_res;
      if (go & set_flags)           flags_q <= flags_d;
    end
  end

  assign flags_out = flags_q;

endmodule

// File: rtl/cae_checker.sv
module cae_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   cond_code,
  input logic [3:0]   alu_op,
  input logic         set_flags,
  input logic         shift_cout,
  input logic [W-1:0] res_out,
  input logic         res_we,
  input logic         executed,
  input logic [3:0]   flags_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags_out == 4'h0 && !res_we && !executed && res_out == '0));

  // R2
  never_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_code == 4'hF) |=> !executed);

  // R3
  we_needs_exec_chk: assert property (@(posedge clk) disable iff (rst)
    res_we |-> executed);

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_out) |-> res_we);

  // R5
  test_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && alu_op[3:2] == 2'b10) |=> !res_we);

  // R6
  logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && set_flags && cond_code == 4'hE &&
     (alu_op[3:1] == 3'b000 || alu_op[3:2] == 2'b11 || alu_op[3:1] == 3'b100))
    |=> (flags_out[0] == $past(flags_out[0]) && flags_out[1] == $past(shift_cout)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && set_flags) |=> $stable(flags_out));

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!executed && !res_we));

endmodule

bind cond_alu_exec cae_checker #(.W(W)) u_cae_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .cond_code  (cond_code),
  .alu_op     (alu_op),
  .set_flags  (set_flags),
  .shift_cout (shift_cout),
  .res_out    (res_out),
  .res_we     (res_we),
  .executed   (executed),
  .flags_out  (flags_out)
);

// File: tb/cond_alu_exec_bench.sv
module cond_alu_exec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   cond_code = 4'h0;
  logic [3:0]   alu_op = 4'h0;
  logic         set_flags = 1'b0;
  logic [W-1:0] op_rn = '0;
  logic [W-1:0] op_shift = '0;
  logic         shift_cout = 1'b0;
  logic [W-1:0] res_out;
  logic         res_we;
  logic         executed;
  logic [3:0]   flags_out;

  int n_vec = 0;
  int n_bad = 0;

  // reference state: what the outputs must show after the next edge
  logic [3:0]  m_flags = 4'h0;
  logic [31:0] m_res = '0;
  logic        m_we = 1'b0;
  logic        m_exec = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_alu_exec #(.W(W)) u_cond_alu_exec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_code(cond_code),
    .alu_op(alu_op), .set_flags(set_flags), .op_rn(op_rn), .op_shift(op_shift),
    .shift_cout(shift_cout), .res_out(res_out), .res_we(res_we),
    .executed(executed), .flags_out(flags_out)
  );

  // R2: selector table, flags are {N,Z,C,V}
  function automatic bit cond_true(input logic [3:0] cc, input logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_outputs(input string tag);
    chk(tag == "" ? "R3" : tag, "executed", {31'b0, executed}, {31'b0, m_exec});
    chk(tag == "" ? "R5" : tag, "res_we", {31'b0, res_we}, {31'b0, m_we});
    chk(tag == "" ? "R4" : tag, "res_out", res_out, m_res);
    chk(tag == "" ? "R9" : tag, "flags", {28'b0, flags_out}, {28'b0, m_flags});
  endtask

  // R6 R7 R8: behavioural reference model of one instruction
  task automatic model(input bit v, input logic [3:0] cc, input logic [3:0] op,
                       input bit s, input logic [31:0] a, input logic [31:0] b,
                       input bit sc);
    bit pass;
    longint ua, ub, sa, sb, u, sv;
    logic [31:0] r;
    bit nc, nv, arith, cin;
    pass = v && cond_true(cc, m_flags);    // R10: flags before this update
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    cin = m_flags[1];
    arith = 1'b1;
    nc = sc;
    nv = m_flags[0];
    u = 0; sv = 0; r = '0;
    case (op)
      4'd4, 4'd11: begin u = ua + ub;       sv = sa + sb;       end
      4'd5:        begin u = ua + ub + cin; sv = sa + sb + cin; end
      4'd2, 4'd10: begin u = ua - ub;       sv = sa - sb;       end
      4'd3:        begin u = ub - ua;       sv = sb - sa;       end
      4'd6:        begin u = ua - ub + cin - 1; sv = sa - sb + cin - 1; end
      4'd7:        begin u = ub - ua + cin - 1; sv = sb - sa + cin - 1; end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      r  = u[31:0];
      if (op == 4'd4 || op == 4'd5 || op == 4'd11) nc = (u >= 64'sd4294967296);
      else nc = (u >= 0);
      nv = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    end else begin
      case (op)
        4'd0, 4'd8: r = a & b;
        4'd1, 4'd9: r = a ^ b;
        4'd12:      r = a | b;
        4'd13:      r = b;
        4'd14:      r = a & ~b;
        default:    r = ~b;
      endcase
    end
    m_exec = pass;
    m_we   = pass && (op[3:2] != 2'b10);
    if (m_we) m_res = r;
    if (pass && s) m_flags = {r[31], (r == 0), nc, nv};
  endtask

  task automatic step(input bit v, input logic [3:0] cc, input logic [3:0] op,
                      input bit s, input logic [31:0] a, input logic [31:0] b,
                      input bit sc, input string tag);
    @(negedge clk);
    compare_outputs(tag);
    in_valid = v; cond_code = cc; alu_op = op; set_flags = s;
    op_rn = a; op_shift = b; shift_cout = sc;
    model(v, cc, op, s, a, b, sc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen at the first compare
    step(1'b0, 4'hE, 4'h0, 1'b0, 32'h0, 32'h0, 1'b0, "R1");
    // R11: idle cycles keep everything
    step(1'b0, 4'hE, 4'hD, 1'b1, 32'h1, 32'hFFFF_FFFF, 1'b1, "R11");
    step(1'b0, 4'hE, 4'h4, 1'b1, 32'h1, 32'h1, 1'b0, "R11");

    // sweep of twelve reachable flag states x selector x operation
    for (int st = 0; st < 16; st++) begin
      bit fn = st[3], fz = st[2], fc = st[1], fv = st[0];
      if (fn && fz) continue;
      for (int cc = 0; cc < 16; cc++) begin
        for (int op = 0; op < 16; op++) begin
          // set V with an add, then N Z C with a move (R6 keeps V)
          step(1'b1, 4'hE, 4'h4, 1'b1, fv ? 32'h7FFF_FFFF : 32'h0,
               fv ? 32'h1 : 32'h0, 1'b0, "");
          step(1'b1, 4'hE, 4'hD, 1'b1, 32'h0,
               fz ? 32'h0 : (fn ? 32'h8000_0000 : 32'h1), fc, "");
          // R2 R3 R4 R5 R7 R8 R9 R10 exercised by the compares
          step(($urandom % 8) != 0, cc[3:0], op[3:0], 1'($urandom % 2),
               $urandom, $urandom, 1'($urandom % 2), "");
        end
      end
    end

    // R7: signed overflow and unsigned carry on addition
    step(1'b1, 4'hE, 4'h4, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0, "R7");
    step(1'b1, 4'hE, 4'h4, 1'b1, 32'hFFFF_FFFF, 32'h1, 1'b0, "R7");
    step(1'b1, 4'hE, 4'h5, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, "R7");
    step(1'b1, 4'hE, 4'hB, 1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0, "R7");
    // R8: borrow and overflow on subtraction, reverse forms
    step(1'b1, 4'hE, 4'h2, 1'b1, 32'h0, 32'h1, 1'b0, "R8");
    step(1'b1, 4'hE, 4'h6, 1'b1, 32'h5, 32'h5, 1'b0, "R8");
    step(1'b1, 4'hE, 4'h2, 1'b1, 32'h5, 32'h5, 1'b0, "R8");
    step(1'b1, 4'hE, 4'h7, 1'b1, 32'h1, 32'h1, 1'b0, "R8");
    step(1'b1, 4'hE, 4'h3, 1'b1, 32'h1, 32'h0, 1'b0, "R8");
    step(1'b1, 4'hE, 4'hA, 1'b1, 32'h8000_0000, 32'h1, 1'b0, "R8");
    step(1'b1, 4'hE, 4'h3, 1'b1, 32'h1, 32'h8000_0000, 1'b0, "R8");
    step(1'b1, 4'hE, 4'h7, 1'b1, 32'h0, 32'h0, 1'b0, "R8");
    // R10: back-to-back dependence on just-written flags
    step(1'b1, 4'hE, 4'h2, 1'b1, 32'h3, 32'h3, 1'b0, "R10");
    step(1'b1, 4'h0, 4'hD, 1'b0, 32'h0, 32'hABCD_0123, 1'b0, "R10");
    step(1'b1, 4'h1, 4'hD, 1'b0, 32'h0, 32'h1111_2222, 1'b0, "R10");
    step(1'b0, 4'hE, 4'h0, 1'b0, 32'h0, 32'h0, 1'b0, "R10");
    step(1'b0, 4'hE, 4'h0, 1'b0, 32'h0, 32'h0, 1'b0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule